// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block moves a stream of data words from one clock domain to an unrelated one. Words are pushed into a small two-port register array on the write clock and popped from it on the read clock. Each side keeps its own binary pointer. The pointer is turned into Gray code before it leaves its domain, so that only one bit moves per step. It then passes through a chain of flip-flops of configurable length on the far clock. Each side compares its own pointer with the synchronized copy of the other to decide whether it is full or empty. Each side also computes a fill level, which drives two early-warning flags with parameterized levels.

The producer holds `wr_en` with `wr_data` and sees a word accepted on any write-clock edge where `wr_full` was low. The consumer holds `rd_en` and receives the popped word on `rd_data` right after any read-clock edge where `rd_empty` was low. All four flags and the read data are registers. Each domain has its own synchronous, active-high reset.

Top module: `afifo_dc`

## Requirements
- R1: After reset, `rd_empty` and `rd_almost_empty` are 1, `wr_full` and `wr_almost_full` are 0, and `rd_data` is 0.
- R2: Words leave the FIFO in the order they were accepted, with unchanged values.
- R3: On a read-clock edge with `rd_en` high and `rd_empty` low, `rd_data` takes the oldest stored word right after that edge. On any other read-clock edge, `rd_data` keeps its value.
- R4: A write presented while `wr_full` is 1 changes neither the stored words nor the write pointer. No extra word is ever read out.
- R5: A read presented while `rd_empty` is 1 moves neither the read pointer nor `rd_data`.
- R6: With reads idle and the read pointer synchronized, `wr_full` rises right after the write-clock edge that accepts word number 2^ADDR_W. It is 0 before that edge.
- R7: `rd_empty` rises right after the read-clock edge that pops the last stored word. After a write into an empty FIFO, `rd_empty` stays 1 for at least one more read-clock edge. It falls within SYNC_STAGES+2 read-clock cycles.
- R8: `wr_almost_full` is 1 exactly when the fill level seen from the write side is at least AF_LEVEL. The write side computes this level as the write pointer minus the synchronized read pointer, after Gray-to-binary conversion.
- R9: `rd_almost_empty` is 1 exactly when the fill level seen from the read side is at most AE_LEVEL.
- R10: Each Gray pointer changes by at most one bit per clock of its own domain. As a result, long concurrent streams across many pointer wraps lose no word and repeat none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No space left (registered) |
| wr_almost_full | output | 1 | Fill level at or above AF_LEVEL (registered) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word popped on the last accepted read |
| rd_empty | output | 1 | Nothing stored (registered) |
| rd_almost_empty | output | 1 | Fill level at or below AE_LEVEL (registered) |

## Verification
A corrupted pointer or a wrong comparison in the flag logic shows at the ports in one of three ways. It can appear as a word out of sequence, a word that is dropped, or a word that is delivered twice. The scoreboard catches each of these on the very next pop. A full or empty flag computed from the wrong pointer shows on the first write-side or read-side edge after the bad state. The bench therefore checks the flags right after every edge during the directed fill and drain. A fault in the Gray crossing tends to appear only near pointer wraps. The long concurrent stream crosses the wrap point many times and exposes such a fault as a data mismatch within a few words.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Least synchronizer length that still lets a metastable first stage settle.
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Pair of status bits one side produces: the hard limit and the early warning.
  typedef struct packed {
    logic limit;
    logic warn;
  } fifo_flags_t;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/afifo_g2b.sv
module afifo_g2b #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] gray,
  output logic [WIDTH-1:0] bin
);

  assign bin[WIDTH-1] = gray[WIDTH-1];

  // Each binary bit is the XOR of all Gray bits at or above it.
  for (genvar i = WIDTH - 1; i > 0; i--) begin : g_bit
    assign bin[i-1] = bin[i] ^ gray[i-1];
  end

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_data <= '0;
    else if (rd_en) rd_data <= store[rd_addr];
  end

endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned AF_LEVEL = 12,
  localparam int unsigned PTR_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  rgray_sync,
  output logic              push,
  output logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  wbin,
  output logic [PTR_W-1:0]  wgray,
  output fifo_flags_t       flags
);

  localparam logic [PTR_W-1:0] AF_L = PTR_W'(AF_LEVEL);

  logic [PTR_W-1:0] wbin_nxt;
  logic [PTR_W-1:0] wgray_nxt;
  logic [PTR_W-1:0] rbin_sync;
  logic [PTR_W-1:0] level_nxt;
  logic [PTR_W-1:0] full_pattern;
  fifo_flags_t      flags_nxt;

  afifo_g2b #(.WIDTH(PTR_W)) u_rcvt (
    .gray (rgray_sync),
    .bin  (rbin_sync)
  );

  assign push      = wr_en & ~flags.limit;
  assign wbin_nxt  = wbin + PTR_W'(push);
  assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
  assign addr      = wbin[ADDR_W-1:0];

  // A full ring differs from the read pointer only in its two top Gray bits.
  assign full_pattern = {~rgray_sync[PTR_W-1:PTR_W-2], rgray_sync[PTR_W-3:0]};
  assign level_nxt    = wbin_nxt - rbin_sync;

  always_comb begin
    flags_nxt.limit = (wgray_nxt == full_pattern);
    flags_nxt.warn  = (level_nxt >= AF_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      flags <= '{limit: 1'b0, warn: 1'b0};
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
      flags <= flags_nxt;
    end
  end

endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned AE_LEVEL = 3,
  localparam int unsigned PTR_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  wgray_sync,
  output logic              pop,
  output logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  rbin,
  output logic [PTR_W-1:0]  rgray,
  output fifo_flags_t       flags
);

  localparam logic [PTR_W-1:0] AE_L = PTR_W'(AE_LEVEL);

  logic [PTR_W-1:0] rbin_nxt;
  logic [PTR_W-1:0] rgray_nxt;
  logic [PTR_W-1:0] wbin_sync;
  logic [PTR_W-1:0] level_nxt;
  fifo_flags_t      flags_nxt;

  afifo_g2b #(.WIDTH(PTR_W)) u_wcvt (
    .gray (wgray_sync),
    .bin  (wbin_sync)
  );

  assign pop       = rd_en & ~flags.limit;
  assign rbin_nxt  = rbin + PTR_W'(pop);
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
  assign addr      = rbin[ADDR_W-1:0];
  assign level_nxt = wbin_sync - rbin_nxt;

  always_comb begin
    flags_nxt.limit = (rgray_nxt == wgray_sync);
    flags_nxt.warn  = (level_nxt <= AE_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      flags <= '{limit: 1'b1, warn: 1'b1};
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rgray_nxt;
      flags <= flags_nxt;
    end
  end

endmodule

// File: rtl/afifo_dc.sv
module afifo_dc
  import afifo_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AF_LEVEL    = 12,
  parameter int unsigned AE_LEVEL    = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_almost_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_almost_empty
);

  localparam int unsigned PTR_W  = ADDR_W + 1;
  localparam int unsigned STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic              push;
  logic              pop;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [PTR_W-1:0]  wptr_bin;
  logic [PTR_W-1:0]  rptr_bin;
  logic [PTR_W-1:0]  wgray;
  logic [PTR_W-1:0]  rgray;
  logic [PTR_W-1:0]  wgray_at_rd;
  logic [PTR_W-1:0]  rgray_at_wr;
  fifo_flags_t       wflags;
  fifo_flags_t       rflags;

  afifo_sync #(.WIDTH(PTR_W), .STAGES(STAGES)) u_r2w (
    .clk (wr_clk),
    .rst (wr_rst),
    .d   (rgray),
    .q   (rgray_at_wr)
  );

  afifo_sync #(.WIDTH(PTR_W), .STAGES(STAGES)) u_w2r (
    .clk (rd_clk),
    .rst (rd_rst),
    .d   (wgray),
    .q   (wgray_at_rd)
  );

  afifo_wr_ctl #(.ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wctl (
    .clk        (wr_clk),
    .rst        (wr_rst),
    .wr_en      (wr_en),
    .rgray_sync (rgray_at_wr),
    .push       (push),
    .addr       (waddr),
    .wbin       (wptr_bin),
    .wgray      (wgray),
    .flags      (wflags)
  );

  afifo_rd_ctl #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rctl (
    .clk        (rd_clk),
    .rst        (rd_rst),
    .rd_en      (rd_en),
    .wgray_sync (wgray_at_rd),
    .pop        (pop),
    .addr       (raddr),
    .rbin       (rptr_bin),
    .rgray      (rgray),
    .flags      (rflags)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk  (wr_clk),
    .wr_en   (push),
    .wr_addr (waddr),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .rd_en   (pop),
    .rd_addr (raddr),
    .rd_data (rd_data)
  );

  assign wr_full         = wflags.limit;
  assign wr_almost_full  = wflags.warn;
  assign rd_empty        = rflags.limit;
  assign rd_almost_empty = rflags.warn;

endmodule

// File: rtl/afifo_dc_chk.sv
module afifo_dc_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 5
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_almost_full,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en,
  input logic              rd_empty,
  input logic              rd_almost_empty,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  wptr_bin,
  input logic [PTR_W-1:0]  rptr_bin,
  input logic [PTR_W-1:0]  wgray,
  input logic [PTR_W-1:0]  rgray
);

  // R1: write-side flags leave reset cleared
  p_wr_reset_state_r1: assert property (@(posedge wr_clk)
    wr_rst |=> (!wr_full && !wr_almost_full));

  // R1: read-side flags leave reset set
  p_rd_reset_state_r1: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_empty && rd_almost_empty));

  // R4: a refused write leaves the write pointer where it was
  p_full_freeze_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && wr_full) |=> $stable(wptr_bin));

  // R5: a refused read leaves the read pointer and output word alone
  p_empty_freeze_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && rd_empty) |=> ($stable(rptr_bin) && $stable(rd_data)));

  // R3: without an accepted read the output word holds
  p_rdata_hold_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(rd_en && !rd_empty) |=> $stable(rd_data));

  // R10: write Gray pointer moves by at most one bit per write clock
  p_wgray_step_r10: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R10: read Gray pointer moves by at most one bit per read clock
  p_rgray_step_r10: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind afifo_dc afifo_dc_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_afifo_dc_chk (
  .wr_clk          (wr_clk),
  .wr_rst          (wr_rst),
  .wr_en           (wr_en),
  .wr_full         (wr_full),
  .wr_almost_full  (wr_almost_full),
  .rd_clk          (rd_clk),
  .rd_rst          (rd_rst),
  .rd_en           (rd_en),
  .rd_empty        (rd_empty),
  .rd_almost_empty (rd_almost_empty),
  .rd_data         (rd_data),
  .wptr_bin        (wptr_bin),
  .rptr_bin        (rptr_bin),
  .wgray           (wgray),
  .rgray           (rgray)
);

// File: tb/test_afifo_dc.sv
module test_afifo_dc;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SYNC      = 2;
  localparam int AF_LEVEL  = 12;
  localparam int AE_LEVEL  = 3;
  localparam int STREAM_N  = 300;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              wr_rst = 1'b1;
  logic              rd_rst = 1'b1;
  logic              wr_en  = 1'b0;
  logic              rd_en  = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              wr_full, wr_almost_full, rd_empty, rd_almost_empty;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] exp_q [$];

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  afifo_dc #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC),
    .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL)
  ) i_afifo_dc (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: offers one word; records it as expected when the FIFO has room.
  task automatic wr_try(input logic [DATA_W-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    acc     = !wr_full;
    if (acc) exp_q.push_back(d);
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
  endtask

  // Monitor: requests one pop and compares the delivered word against the queue.
  task automatic rd_try(output bit acc, output logic [DATA_W-1:0] got);
    logic [DATA_W-1:0] exp;
    @(negedge rd_clk);
    rd_en = 1'b1;
    acc   = !rd_empty;
    @(posedge rd_clk);
    #1 rd_en = 1'b0;
    got = rd_data;
    if (acc) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 extra word read", int'(got), -1);
      end else begin
        exp = exp_q.pop_front();
        chk(got == exp, "R2 data order/value", int'(got), int'(exp));
      end
    end
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [DATA_W-1:0] got;
    logic [DATA_W-1:0] last;
    int n_rd;

    repeat (5) @(posedge rd_clk);
    #1;
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    repeat (4) @(posedge rd_clk);
    #1;

    // R1: reset state
    chk(rd_empty == 1'b1,        "R1 rd_empty",        rd_empty, 1);
    chk(rd_almost_empty == 1'b1, "R1 rd_almost_empty", rd_almost_empty, 1);
    chk(wr_full == 1'b0,         "R1 wr_full",         wr_full, 0);
    chk(wr_almost_full == 1'b0,  "R1 wr_almost_full",  wr_almost_full, 0);
    chk(rd_data == '0,           "R1 rd_data",         int'(rd_data), 0);

    // Fill with reads idle: R6 full timing and R8 almost-full level
    for (int k = 1; k <= DEPTH; k++) begin
      wr_try(DATA_W'(8'h10 + k), acc);
      chk(acc, "R6 write accepted before full", acc, 1);
      chk(wr_full == (k == DEPTH), "R6 wr_full after write", wr_full, int'(k == DEPTH));
      chk(wr_almost_full == (k >= AF_LEVEL), "R8 wr_almost_full level",
          wr_almost_full, int'(k >= AF_LEVEL));
      if (k == 1) begin
        // R7: one read edge later the write pointer has not yet crossed
        @(posedge rd_clk);
        #1 chk(rd_empty == 1'b1, "R7 empty held during sync", rd_empty, 1);
        repeat (SYNC + 1) @(posedge rd_clk);
        #1 chk(rd_empty == 1'b0, "R7 empty falls after sync", rd_empty, 0);
      end
    end

    // R4: writes refused while full
    for (int i = 0; i < 3; i++) begin
      wr_try(DATA_W'(8'hE0 + i), acc);
      chk(!acc && wr_full, "R4 write refused while full", wr_full, 1);
    end

    repeat (SYNC + 4) @(posedge rd_clk);
    #1;

    // Drain: R9 almost-empty level, R7 empty at last pop, R2 via scoreboard
    for (int j = 1; j <= DEPTH; j++) begin
      rd_try(acc, got);
      chk(acc, "R2 read accepted", acc, 1);
      chk(rd_empty == (j == DEPTH), "R7 rd_empty after pop", rd_empty, int'(j == DEPTH));
      chk(rd_almost_empty == ((DEPTH - j) <= AE_LEVEL), "R9 rd_almost_empty level",
          rd_almost_empty, int'((DEPTH - j) <= AE_LEVEL));
    end
    chk(exp_q.size() == 0, "R4 no refused word stored", exp_q.size(), 0);
    last = rd_data;

    // R3: output holds without reads
    repeat (3) @(posedge rd_clk);
    #1 chk(rd_data == last, "R3 rd_data holds when idle", int'(rd_data), int'(last));

    // R5: read on empty changes nothing visible
    rd_try(acc, got);
    chk(!acc && got == last, "R5 rd_data unchanged on empty read", int'(got), int'(last));
    chk(rd_empty == 1'b1, "R5 still empty", rd_empty, 1);
    wr_try(8'hA5, acc);
    repeat (SYNC + 3) @(posedge rd_clk);
    rd_try(acc, got);
    chk(acc && got == 8'hA5, "R5 read pointer not moved by empty read", int'(got), 8'hA5);

    // R10: concurrent stream across many pointer wraps
    fork
      begin
        for (int i = 0; i < STREAM_N; i++) begin
          bit a;
          repeat ($urandom % 3) @(negedge wr_clk);
          do wr_try(DATA_W'(i * 7 + 3), a); while (!a);
        end
      end
      begin
        n_rd = 0;
        while (n_rd < STREAM_N) begin
          bit a;
          logic [DATA_W-1:0] g;
          repeat ($urandom % 3) @(negedge rd_clk);
          rd_try(a, g);
          if (a) n_rd++;
        end
      end
    join
    repeat (SYNC + 4) @(posedge rd_clk);
    #1;
    chk(exp_q.size() == 0, "R10 stream fully delivered", exp_q.size(), 0);
    chk(rd_empty == 1'b1, "R10 empty after stream", rd_empty, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule